// File: doc/BRIEF.md
# Compressed Byte/Halfword and Bit-Manipulation Instruction Decoder

This block takes one 16-bit compressed instruction from a subset that covers narrow loads and stores, unary extend/invert operations and a low-half multiply. It decides whether the halfword belongs to the subset and which operation it encodes. It then pulls out the register indices and the small unsigned offset. For register-only operations it computes the 64-bit writeback value from the source operand values the caller supplies. For loads and stores it forms the effective address and reports the access size and signedness.

A pipeline stage places it beside the ordinary decoder. The stage presents the instruction with a valid strobe and the values read for both source registers. One cycle later the registered outputs hold the classification, the operands and the computed value. The register file, the memory access and the 32-bit instruction path live outside this block.

Top module: `cmp_bitops_dec`

## Requirements
- R1: An instruction is in the subset only when bits [15:13] are 3'b100 and bits [1:0] are 2'b00 or 2'b01. Any other halfword is reported illegal with op code 0.
- R2: A 3-bit register field n selects register index n+8. In quadrant 00, rs1 comes from bits [9:7]. A load's rd comes from bits [4:2], and a store's rs2 comes from bits [4:2]. In quadrant 01, rd and rs1 both come from bits [9:7], and a multiply's rs2 comes from bits [4:2]. An index an operation does not use reads 0.
- R3: In quadrant 00, bits [12:10] select the operation: 000 is an unsigned byte load, 001 a halfword load, 010 a byte store and 011 a halfword store. The values 100 to 111 are illegal.
- R4: For the byte load and the byte store, the 2-bit offset has instruction bit 5 as offset bit 1 and instruction bit 6 as offset bit 0.
- R5: For the halfword forms, the offset is bit 5 times 2. On a halfword load, bit 6 = 1 selects sign extension (signed_o = 1) and bit 6 = 0 selects zero extension. On a halfword store, bit 6 = 1 is illegal. size_o is 0 for a byte access and 1 for a halfword access.
- R6: In quadrant 01, bit 12 must be 1 and bits [11:10] must be 2'b11. Otherwise the instruction is illegal.
- R7: In quadrant 01 with bits [6:5] = 11, bits [4:2] select a unary operation on the rs1 value: 000 zero-extend byte, 001 sign-extend byte, 010 zero-extend halfword, 011 sign-extend halfword, 100 zero-extend word, 101 bitwise NOT. The codes 110 and 111 are illegal.
- R8: In quadrant 01 with bits [6:5] = 10, the result is the low 64 bits of rs1 × rs2. The values 00 and 01 in bits [6:5] are illegal.
- R9: For a load or store, addr_o = rs1 value + zero-extended offset, modulo 2^64. For every other operation, addr_o, size_o and signed_o are 0. For loads and stores, result_o is 0.
- R10: The op codes are: 0 none, 1 byte load unsigned, 2 halfword load unsigned, 3 halfword load signed, 4 byte store, 5 halfword store, 6 zero-extend byte, 7 sign-extend byte, 8 zero-extend halfword, 9 sign-extend halfword, 10 zero-extend word, 11 NOT, 12 multiply.
- R11: valid_o equals valid_i from the previous cycle. Reset clears every output to 0. The data outputs load only in a cycle where valid_i is high, and otherwise they hold.
- R12: An illegal instruction sets illegal_o. It also forces op_o, the indices, the offset, addr_o, result_o, size_o and signed_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 16 | Compressed instruction halfword |
| rs1_val_i | input | 64 | Value of the first source register |
| rs2_val_i | input | 64 | Value of the second source register |
| valid_o | output | 1 | Outputs belong to an accepted instruction |
| illegal_o | output | 1 | Not decodable in this subset |
| op_o | output | 4 | Operation code |
| rd_idx_o | output | 5 | Destination register index |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| imm_o | output | 2 | Unsigned byte offset |
| addr_o | output | 64 | Effective address |
| size_o | output | 1 | Access size, 0 byte, 1 halfword |
| signed_o | output | 1 | Loaded halfword is sign-extended |
| result_o | output | 64 | Writeback value |

## Verification
The cases that are hardest to reach are the illegal encodings that differ from a legal one by a single bit. Examples are a halfword store with bit 6 set, unary codes 110 and 111, and quadrant-01 words with bit 12 or bits [11:10] cleared. Uniform random halfwords almost never land on these. The stimulus therefore writes them out directly. Its random phase builds most words from the fixed subset prefix plus random low fields. Address wrap-around is driven with all-ones base values.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_LB_U  = 4'd1,
    OP_LH_U  = 4'd2,
    OP_LH_S  = 4'd3,
    OP_SB    = 4'd4,
    OP_SH    = 4'd5,
    OP_ZX_B  = 4'd6,
    OP_SX_B  = 4'd7,
    OP_ZX_H  = 4'd8,
    OP_SX_H  = 4'd9,
    OP_ZX_W  = 4'd10,
    OP_INV   = 4'd11,
    OP_MUL   = 4'd12
  } op_e;

  function automatic logic is_mem(op_e op);
    return (op == OP_LB_U) || (op == OP_LH_U) || (op == OP_LH_S) ||
           (op == OP_SB) || (op == OP_SH);
  endfunction
endpackage

// File: rtl/cbd_field_decode.sv
module cbd_field_decode
  import cbd_pkg::*;
#(
  parameter int ILEN  = 16,
  parameter int REG_W = 5,
  parameter int IMM_W = 2
) (
  input  logic [ILEN-1:0]  instr_i,
  output op_e              op_o,
  output logic             illegal_o,
  output logic [REG_W-1:0] rd_idx_o,
  output logic [REG_W-1:0] rs1_idx_o,
  output logic [REG_W-1:0] rs2_idx_o,
  output logic [IMM_W-1:0] imm_o,
  output logic             size_o,
  output logic             signed_o
);
  localparam int FLD_W = 3;
  localparam logic [REG_W-1:0] WIN_BASE = REG_W'(8);

  logic [REG_W-1:0] hi_reg, lo_reg;
  logic             prefix_ok;

  assign hi_reg    = REG_W'(instr_i[9:7]) + WIN_BASE;
  assign lo_reg    = REG_W'(instr_i[4:2]) + WIN_BASE;
  assign prefix_ok = (instr_i[15:13] == 3'b100);

  always_comb begin
    op_o      = OP_NONE;
    illegal_o = 1'b1;
    rd_idx_o  = '0;
    rs1_idx_o = '0;
    rs2_idx_o = '0;
    imm_o     = '0;
    size_o    = 1'b0;
    signed_o  = 1'b0;
    if (prefix_ok && instr_i[1:0] == 2'b00) begin
      unique case (instr_i[12:10])
        3'b000: begin
          op_o = OP_LB_U; illegal_o = 1'b0;
          rs1_idx_o = hi_reg; rd_idx_o = lo_reg;
          imm_o = IMM_W'({instr_i[5], instr_i[6]});  // offset bits swapped
        end
        3'b001: begin
          op_o = instr_i[6] ? OP_LH_S : OP_LH_U; illegal_o = 1'b0;
          rs1_idx_o = hi_reg; rd_idx_o = lo_reg;
          imm_o = IMM_W'({instr_i[5], 1'b0});
          size_o = 1'b1; signed_o = instr_i[6];
        end
        3'b010: begin
          op_o = OP_SB; illegal_o = 1'b0;
          rs1_idx_o = hi_reg; rs2_idx_o = lo_reg;
          imm_o = IMM_W'({instr_i[5], instr_i[6]});
        end
        3'b011: begin
          if (!instr_i[6]) begin
            op_o = OP_SH; illegal_o = 1'b0;
            rs1_idx_o = hi_reg; rs2_idx_o = lo_reg;
            imm_o = IMM_W'({instr_i[5], 1'b0});
            size_o = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (prefix_ok && instr_i[1:0] == 2'b01 && instr_i[12:10] == 3'b111) begin
      unique case (instr_i[6:5])
        2'b11: begin
          illegal_o = 1'b0;
          unique case (instr_i[4:2])
            3'b000:  op_o = OP_ZX_B;
            3'b001:  op_o = OP_SX_B;
            3'b010:  op_o = OP_ZX_H;
            3'b011:  op_o = OP_SX_H;
            3'b100:  op_o = OP_ZX_W;
            3'b101:  op_o = OP_INV;
            default: illegal_o = 1'b1;
          endcase
          if (!illegal_o) begin
            rd_idx_o = hi_reg; rs1_idx_o = hi_reg;
          end
        end
        2'b10: begin
          op_o = OP_MUL; illegal_o = 1'b0;
          rd_idx_o = hi_reg; rs1_idx_o = hi_reg; rs2_idx_o = lo_reg;
        end
        default: ;
      endcase
    end
  end

  // R12
  illegal_none_chk: assert final (!illegal_o || (op_o == OP_NONE && imm_o == '0));
  // R2
  window_chk: assert final (illegal_o || rs1_idx_o[REG_W-1:FLD_W] == 2'b01);
endmodule

// File: rtl/cbd_unary_mul.sv
module cbd_unary_mul
  import cbd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int B_W = 8;
  localparam int H_W = 16;
  localparam int W_W = 32;

  logic [XLEN-1:0] prod;
  assign prod = a_i * b_i;

  always_comb begin
    unique case (op_i)
      OP_ZX_B: res_o = XLEN'(a_i[B_W-1:0]);
      OP_SX_B: res_o = {{(XLEN-B_W){a_i[B_W-1]}}, a_i[B_W-1:0]};
      OP_ZX_H: res_o = XLEN'(a_i[H_W-1:0]);
      OP_SX_H: res_o = {{(XLEN-H_W){a_i[H_W-1]}}, a_i[H_W-1:0]};
      OP_ZX_W: res_o = XLEN'(a_i[W_W-1:0]);
      OP_INV:  res_o = ~a_i;
      OP_MUL:  res_o = prod;
      default: res_o = '0;
    endcase
  end

  // R7
  zext_byte_chk: assert final (op_i != OP_ZX_B || res_o[XLEN-1:B_W] == '0);
endmodule

// File: rtl/cbd_addr_gen.sv
module cbd_addr_gen #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 2
) (
  input  logic             en_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] off_i,
  output logic [XLEN-1:0]  addr_o
);
  always_comb addr_o = en_i ? (base_i + XLEN'(off_i)) : '0;
endmodule

// File: rtl/cmp_bitops_dec.sv
module cmp_bitops_dec
  import cbd_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int ILEN  = 16,
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [ILEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  rs1_val_i,
  input  logic [XLEN-1:0]  rs2_val_i,
  output logic             valid_o,
  output logic             illegal_o,
  output logic [3:0]       op_o,
  output logic [REG_W-1:0] rd_idx_o,
  output logic [REG_W-1:0] rs1_idx_o,
  output logic [REG_W-1:0] rs2_idx_o,
  output logic [1:0]       imm_o,
  output logic [XLEN-1:0]  addr_o,
  output logic             size_o,
  output logic             signed_o,
  output logic [XLEN-1:0]  result_o
);
  localparam int IMM_W = 2;

  op_e              d_op;
  logic             d_ill, d_size, d_sgn;
  logic [REG_W-1:0] d_rd, d_rs1, d_rs2;
  logic [IMM_W-1:0] d_imm;
  logic [XLEN-1:0]  d_res, d_addr;

  cbd_field_decode #(.ILEN(ILEN), .REG_W(REG_W), .IMM_W(IMM_W)) i_dec (
    .instr_i  (instr_i),
    .op_o     (d_op),
    .illegal_o(d_ill),
    .rd_idx_o (d_rd),
    .rs1_idx_o(d_rs1),
    .rs2_idx_o(d_rs2),
    .imm_o    (d_imm),
    .size_o   (d_size),
    .signed_o (d_sgn)
  );

  cbd_unary_mul #(.XLEN(XLEN)) i_alu (
    .op_i (d_op),
    .a_i  (rs1_val_i),
    .b_i  (rs2_val_i),
    .res_o(d_res)
  );

  cbd_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) i_agu (
    .en_i  (is_mem(d_op)),
    .base_i(rs1_val_i),
    .off_i (d_imm),
    .addr_o(d_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      illegal_o <= 1'b0;
      op_o      <= '0;
      rd_idx_o  <= '0;
      rs1_idx_o <= '0;
      rs2_idx_o <= '0;
      imm_o     <= '0;
      addr_o    <= '0;
      size_o    <= 1'b0;
      signed_o  <= 1'b0;
      result_o  <= '0;
    end else if (valid_i) begin
      illegal_o <= d_ill;
      op_o      <= d_op;
      rd_idx_o  <= d_rd;
      rs1_idx_o <= d_rs1;
      rs2_idx_o <= d_rs2;
      imm_o     <= d_imm;
      addr_o    <= d_addr;
      size_o    <= d_size;
      signed_o  <= d_sgn;
      result_o  <= d_res;
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R11
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(op_o) && $stable(result_o) && $stable(addr_o));
  // R12
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0) && (addr_o == '0) && (op_o == 4'd0));
  // R5
  size_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_o |-> (op_o == 4'd2 || op_o == 4'd3 || op_o == 4'd5));
  // R5
  signed_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    signed_o |-> op_o == 4'd3);
  // R9
  mem_no_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o >= 4'd1 && op_o <= 4'd5) |-> result_o == '0);
endmodule

// File: tb/test_cmp_bitops_dec.sv
module test_cmp_bitops_dec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [63:0] rs1_val_i = '0, rs2_val_i = '0;
  logic        valid_o, illegal_o, size_o, signed_o;
  logic [3:0]  op_o;
  logic [4:0]  rd_idx_o, rs1_idx_o, rs2_idx_o;
  logic [1:0]  imm_o;
  logic [63:0] addr_o, result_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // expected state
  logic        e_valid = 0, e_ill = 0, e_size = 0, e_sgn = 0;
  logic [3:0]  e_op = 0;
  logic [4:0]  e_rd = 0, e_rs1 = 0, e_rs2 = 0;
  logic [1:0]  e_imm = 0;
  logic [63:0] e_addr = 0, e_res = 0;
  string       e_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_bitops_dec i_cmp_bitops_dec (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .valid_o(valid_o),
    .illegal_o(illegal_o), .op_o(op_o), .rd_idx_o(rd_idx_o),
    .rs1_idx_o(rs1_idx_o), .rs2_idx_o(rs2_idx_o), .imm_o(imm_o),
    .addr_o(addr_o), .size_o(size_o), .signed_o(signed_o), .result_o(result_o)
  );

  task automatic cmp(string tag, string fld, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, fld, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("R11", "valid", 64'(valid_o), 64'(e_valid));
    cmp(e_tag, "illegal", 64'(illegal_o), 64'(e_ill));
    cmp("R10", "op", 64'(op_o), 64'(e_op));
    cmp("R2", "rd", 64'(rd_idx_o), 64'(e_rd));
    cmp("R2", "rs1", 64'(rs1_idx_o), 64'(e_rs1));
    cmp("R2", "rs2", 64'(rs2_idx_o), 64'(e_rs2));
    cmp("R4", "imm", 64'(imm_o), 64'(e_imm));
    cmp(e_ill ? "R12" : "R9", "addr", addr_o, e_addr);
    cmp("R5", "size", 64'(size_o), 64'(e_size));
    cmp("R5", "signed", 64'(signed_o), 64'(e_sgn));
    cmp(e_ill ? "R12" : e_tag, "result", result_o, e_res);
  endtask

  // behavioural reference
  task automatic model(logic [15:0] w, logic [63:0] a, logic [63:0] b);
    int q, top, mid, f65, lo, hi_r, lo_r;
    q = int'(w[1:0]); top = int'(w[15:13]); mid = int'(w[12:10]);
    f65 = int'(w[6:5]); lo = int'(w[4:2]);
    hi_r = int'(w[9:7]) + 8; lo_r = lo + 8;
    e_ill = 1; e_op = 0; e_rd = 0; e_rs1 = 0; e_rs2 = 0; e_imm = 0;
    e_addr = 0; e_res = 0; e_size = 0; e_sgn = 0; e_tag = "R1";
    if (top != 4 || q > 1) return;
    if (q == 0) begin
      e_tag = "R3";
      if (mid >= 4) return;
      if (mid == 3 && w[6]) begin e_tag = "R5"; return; end
      e_ill = 0;
      e_rs1 = 5'(hi_r);
      if (mid == 0 || mid == 2) e_imm = 2'(2 * int'(w[5]) + int'(w[6]));
      else begin e_imm = 2'(2 * int'(w[5])); e_size = 1; e_tag = "R5"; end
      if (mid == 0) begin e_op = 1; e_rd = 5'(lo_r); end
      if (mid == 1) begin e_op = w[6] ? 3 : 2; e_sgn = w[6]; e_rd = 5'(lo_r); end
      if (mid == 2) begin e_op = 4; e_rs2 = 5'(lo_r); end
      if (mid == 3) begin e_op = 5; e_rs2 = 5'(lo_r); end
      e_addr = a + 64'(e_imm);
      return;
    end
    e_tag = "R6";
    if (mid != 7) return;
    if (f65 == 3) begin
      e_tag = "R7";
      if (lo > 5) return;
      e_ill = 0; e_op = 4'(6 + lo); e_rd = 5'(hi_r); e_rs1 = 5'(hi_r);
      case (lo)
        0: e_res = a & 64'hFF;
        1: e_res = 64'($signed(a[7:0]));
        2: e_res = a & 64'hFFFF;
        3: e_res = 64'($signed(a[15:0]));
        4: e_res = a & 64'hFFFF_FFFF;
        default: e_res = a ^ {64{1'b1}};
      endcase
    end else begin
      e_tag = "R8";
      if (f65 != 2) return;
      e_ill = 0; e_op = 12; e_rd = 5'(hi_r); e_rs1 = 5'(hi_r); e_rs2 = 5'(lo_r);
      e_res = a * b;
    end
  endtask

  task automatic step(logic v, logic [15:0] w, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    compare_all();
    valid_i = v; instr_i = w; rs1_val_i = a; rs2_val_i = b;
    e_valid = v;
    if (v) model(w, a, b);
  endtask

  function automatic logic [15:0] q0(logic [2:0] sub, logic [2:0] r1, logic b6,
                                     logic b5, logic [2:0] r2);
    return {3'b100, sub, r1, b6, b5, r2, 2'b00};
  endfunction

  function automatic logic [15:0] q1(logic [2:0] r, logic [1:0] f, logic [2:0] s);
    return {3'b100, 1'b1, 2'b11, r, f, s, 2'b01};
  endfunction

  localparam logic [63:0] ONES = {64{1'b1}};

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R11
    compare_all();
    rst_ni = 1'b1;
    // R4 swapped offset bits, R9 wrap
    step(1, q0(3'b000, 3'd0, 1'b1, 1'b0, 3'd7), 64'h1000, 0);
    step(1, q0(3'b000, 3'd5, 1'b0, 1'b1, 3'd1), ONES, 0);
    step(1, q0(3'b010, 3'd7, 1'b1, 1'b1, 3'd2), ONES - 1, 0);
    // R5 halfword forms
    step(1, q0(3'b001, 3'd2, 1'b1, 1'b1, 3'd3), 64'h20, 0);
    step(1, q0(3'b001, 3'd2, 1'b0, 1'b1, 3'd3), 64'h20, 0);
    step(1, q0(3'b011, 3'd1, 1'b0, 1'b1, 3'd4), ONES, 0);
    step(1, q0(3'b011, 3'd1, 1'b1, 1'b0, 3'd4), 64'h40, 0);
    // R3 reserved sub-ops
    for (int k = 4; k < 8; k++) step(1, q0(3'(k), 3'd3, 1'b1, 1'b1, 3'd3), 64'h5, 0);
    // R7 every unary code, including 110/111
    for (int k = 0; k < 8; k++) step(1, q1(3'd6, 2'b11, 3'(k)), 64'h8000_0000_8000_80F0, 0);
    // R8 multiply and illegal [6:5]
    step(1, q1(3'd0, 2'b10, 3'd7), ONES, ONES);
    step(1, q1(3'd4, 2'b10, 3'd1), 64'h1_0000_0001, 64'h1_0000_0003);
    step(1, q1(3'd4, 2'b00, 3'd1), 64'h3, 64'h5);
    step(1, q1(3'd4, 2'b01, 3'd1), 64'h3, 64'h5);
    // R6 prefix violations
    step(1, {3'b100, 1'b0, 2'b11, 3'd1, 2'b11, 3'd0, 2'b01}, 64'hFF, 0);
    step(1, {3'b100, 1'b1, 2'b10, 3'd1, 2'b11, 3'd0, 2'b01}, 64'hFF, 0);
    // R1 outside subset
    step(1, {3'b100, 13'b0_1111_1111_1110}, 64'h7, 0);
    step(1, {3'b000, 13'b0_0000_0000_0000}, 64'h7, 0);
    step(1, {3'b101, 13'b1_1100_0111_0001}, 64'h7, 0);
    // R11 hold with valid low, R12 illegal zeroing above
    step(0, q1(3'd0, 2'b10, 3'd7), 64'h9, 64'h9);
    step(0, 16'hFFFF, 0, 0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] w;
      logic [63:0] a, b;
      int k;
      k = int'($urandom_range(0, 9));
      w = 16'($urandom);
      if (k < 4)      w = {3'b100, w[12:2], 2'b00};
      else if (k < 8) w = {6'b100111, w[9:2], 2'b01};
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k == 9) a = ONES;
      step(($urandom_range(0, 4) != 0), w, a, b);
    end
    step(0, 0, 0, 0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule